// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block chooses which of twelve interrupt requests the CPU services next and tells it where the service routine is entered. The requests are an undefined-opcode trap, an edge-triggered non-maskable pin, a primary maskable pin with three entry modes, two auxiliary maskable pins, and seven internal request lines. These cover two timers, two DMA channels, a clocked serial port and two UART channels. The block holds a vector page register, a 3-bit table-slot field and a control register. The control register has per-pin enables and the trap status bits.

When the CPU pulses `ack`, the block takes the highest-priority eligible request in that clock edge. It registers the winning source number, a 16-bit entry address and the kind of entry. The outputs then hold until the next acknowledge. The CPU does its own instruction decoding, stacking and data-bus fetch. For a table entry, the CPU reads the routine address from the table at `vec_addr`. For a restart, the CPU jumps to `vec_addr` directly. For a bus opcode, the CPU executes the byte that the device supplies.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the block presents `vec_src`=0, `vec_addr`=0000h, `vec_kind`=0 and `trap_flag`=`trap_byte2`=0. The page register and slot field are zero. The primary pin enable is 1 and both auxiliary pin enables are 0.
- R2: An acknowledge takes the eligible request of highest priority. The order is trap (source 0), non-maskable (1), primary pin (2), auxiliary pin 1 (3), auxiliary pin 2 (4), then internal lines 0..6 (sources 5..11).
- R3: For sources 3..11, `vec_kind`=1 (table) and `vec_addr` = {page[7:0], slot[2:0], code[4:0]}. The code is twice the source's position k in that list (k = source − 3), giving 00000, 00010 … 10000.
- R4: A rising edge on `nmi_pin` is latched until that request is acknowledged, whatever `gie` is. It enters as a restart (`vec_kind`=0) at 0066h. A pin that stays high raises only one request.
- R5: For the primary pin, `int_mode`=0 gives `vec_kind`=2 (opcode from bus) with `vec_addr`=0000h. Mode 1 gives a restart at 0038h. Modes 2 and 3 give `vec_kind`=1 with `vec_addr` = {page, `bus_byte` sampled at the acknowledge edge}.
- R6: A pulse on `undef_op` latches a trap request, which enters as a restart at 0000h. The same pulse sets `trap_flag` and loads `trap_byte2` from `undef_second`. Neither status bit changes on acknowledge.
- R7: A control write with data bit 7 = 0 clears `trap_flag`, and a control write with bit 7 = 1 leaves it unchanged. A new trap pulse in the same cycle as a clearing write wins.
- R8: Control bits 0, 1 and 2 enable the primary pin and auxiliary pins 1 and 2. These pins are level-sensitive and are eligible only while their enable bit and `gie` are both 1. The internal lines are gated by `gie` alone.
- R9: Outputs change only on a cycle with `ack` high and `irq_pending` high. An acknowledge with nothing eligible leaves all three vector outputs unchanged.
- R10: Configuration writes use `cfg_addr` 0 for the page register (all data bits), 1 for the slot field (data bits 2:0) and 2 for the control register.
- R11: `irq_pending` is high exactly while at least one source is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| gie | input | 1 | Global maskable-interrupt enable from CPU |
| int_mode | input | 2 | Entry mode of the primary pin |
| undef_op | input | 1 | Undefined opcode detected (pulse) |
| undef_second | input | 1 | Undefined byte was the second opcode byte |
| nmi_pin | input | 1 | Non-maskable request, rising-edge |
| ext_pin | input | 3 | Maskable pins: bit 0 primary, bits 1–2 auxiliary |
| int_req | input | 7 | Internal request lines (timers, DMA, serial, UARTs) |
| bus_byte | input | 8 | Low table byte offered on the data bus |
| ack | input | 1 | Interrupt acknowledge pulse |
| irq_pending | output | 1 | Some source is eligible |
| vec_src | output | 4 | Acknowledged source number |
| vec_kind | output | 2 | 0 restart, 1 table entry, 2 opcode from bus |
| vec_addr | output | 16 | Restart or table address |
| trap_flag | output | 1 | Trap occurred status |
| trap_byte2 | output | 1 | Trap was on the second opcode byte |

## Verification
The bench uses the default parameters: an 8-bit page, two auxiliary pins and seven internal lines. With these defaults all nine table slots are in use, including the last code 10000, so code bit 4 is exercised. A full priority sweep also runs across every maskable slot. The twelve source numbers fill a 4-bit field, so the highest source number (11) is reachable. With seven internal lines, a priority pass that drops the winner one step at a time takes only nine acknowledges. That leaves room in the run for the trap, edge and status corner cases.

// File: rtl/irqv_pkg.sv
// Shared constants and types for the vectored interrupt controller.
// Assumes source numbers are fixed by priority: lower number wins.
package irqv_pkg;
    typedef enum logic [1:0] {
        VK_RESTART = 2'd0,
        VK_TABLE   = 2'd1,
        VK_BUSOP   = 2'd2
    } vkind_e;

    localparam int SRC_TRAP  = 0;
    localparam int SRC_NMI   = 1;
    localparam int SRC_PRI   = 2;
    localparam int SRC_SLOT0 = 3;   // first source using a table slot code

    localparam logic [1:0] CFG_PAGE = 2'd0;
    localparam logic [1:0] CFG_SLOT = 2'd1;
    localparam logic [1:0] CFG_CTRL = 2'd2;

    localparam int CTRL_TRAP_BIT = 7;
    localparam int SLOT_W        = 3;
    localparam int CODE_W        = 5;

    localparam logic [15:0] ADDR_NMI  = 16'h0066;
    localparam logic [15:0] ADDR_PRI1 = 16'h0038;
endpackage

// File: rtl/irqv_regs.sv
// Configuration registers: vector page, table-slot field, per-pin enables
// and the trap status pair. Assumes PAGE_W >= 8 so control bit 7 exists.
module irqv_regs
    import irqv_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int N_AUX  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [PAGE_W-1:0] cfg_wdata,
    input  logic              undef_op,
    input  logic              undef_second,
    output logic [PAGE_W-1:0] page_q,
    output logic [SLOT_W-1:0] slot_q,
    output logic [N_AUX:0]    pin_en,
    output logic              trap_flag,
    output logic              trap_byte2
);
    // Page, slot and enable registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            slot_q <= '0;
            pin_en <= (N_AUX+1)'(1);
        end else if (cfg_we) begin
            case (cfg_addr)
                CFG_PAGE: page_q <= cfg_wdata;
                CFG_SLOT: slot_q <= cfg_wdata[SLOT_W-1:0];
                CFG_CTRL: pin_en <= cfg_wdata[N_AUX:0];
                default:  ;
            endcase
        end
    end

    // Trap status: hardware set has precedence over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_flag  <= 1'b0;
            trap_byte2 <= 1'b0;
        end else if (undef_op) begin
            trap_flag  <= 1'b1;
            trap_byte2 <= undef_second;
        end else if (cfg_we && cfg_addr == CFG_CTRL && !cfg_wdata[CTRL_TRAP_BIT]) begin
            trap_flag  <= 1'b0;
        end
    end
endmodule

// File: rtl/irqv_req.sv
// Request conditioning: latches trap and non-maskable edges until taken,
// gates level-sensitive pins and internal lines with their enables.
// Assumes take_* pulse only in a cycle where that source wins an ack.
module irqv_req #(
    parameter int N_AUX = 2,
    parameter int N_INT = 7,
    localparam int N_SRC = 3 + N_AUX + N_INT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_pin,
    input  logic             undef_op,
    input  logic [N_AUX:0]   ext_pin,
    input  logic [N_INT-1:0] int_req,
    input  logic             gie,
    input  logic [N_AUX:0]   pin_en,
    input  logic             take_trap,
    input  logic             take_nmi,
    output logic [N_SRC-1:0] eligible,
    output logic             trap_pend,
    output logic             nmi_pend
);
    logic nmi_d;

    // Edge detector history for the non-maskable pin.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_d <= 1'b0;
        else        nmi_d <= nmi_pin;
    end

    // Latched requests: a new event outranks the clear from an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_pend <= 1'b0;
            nmi_pend  <= 1'b0;
        end else begin
            if (undef_op)       trap_pend <= 1'b1;
            else if (take_trap) trap_pend <= 1'b0;
            if (nmi_pin && !nmi_d) nmi_pend <= 1'b1;
            else if (take_nmi)     nmi_pend <= 1'b0;
        end
    end

    // Unmasked sources at the top of the priority order.
    always_comb begin
        eligible[0] = trap_pend;
        eligible[1] = nmi_pend;
        eligible[2] = gie & pin_en[0] & ext_pin[0];
    end

    // Auxiliary pins, each with its own enable bit.
    for (genvar a = 0; a < N_AUX; a++) begin : g_aux
        assign eligible[3+a] = gie & pin_en[a+1] & ext_pin[a+1];
    end

    // Internal lines, gated by the global enable only.
    for (genvar i = 0; i < N_INT; i++) begin : g_int
        assign eligible[3+N_AUX+i] = gie & int_req[i];
    end
endmodule

// File: rtl/irqv_arb.sv
// Fixed-priority pick of the lowest-numbered eligible source and the
// entry address it uses. Purely combinational; the top registers it.
module irqv_arb
    import irqv_pkg::*;
#(
    parameter int N_SRC  = 12,
    parameter int PAGE_W = 8,
    localparam int SRC_W = $clog2(N_SRC),
    localparam int VEC_W = PAGE_W + 8
) (
    input  logic [N_SRC-1:0]  eligible,
    input  logic [1:0]        int_mode,
    input  logic [PAGE_W-1:0] page_q,
    input  logic [SLOT_W-1:0] slot_q,
    input  logic [7:0]        bus_byte,
    output logic              any,
    output logic [SRC_W-1:0]  win,
    output vkind_e            kind,
    output logic [VEC_W-1:0]  addr
);
    logic [CODE_W-1:0] code;

    // Priority encoder: the last hit scanning downward is the lowest number.
    always_comb begin
        any = 1'b0;
        win = '0;
        for (int i = N_SRC-1; i >= 0; i--) begin
            if (eligible[i]) begin
                any = 1'b1;
                win = SRC_W'(i);
            end
        end
    end

    // Slot code is twice the position among table-slot sources.
    assign code = CODE_W'((32'(win) - SRC_SLOT0) * 2);

    // Entry address and kind for the winning source.
    always_comb begin
        kind = VK_RESTART;
        addr = '0;
        if (win == SRC_W'(SRC_NMI)) begin
            addr = VEC_W'(ADDR_NMI);
        end else if (win == SRC_W'(SRC_PRI)) begin
            if (int_mode[1]) begin
                kind = VK_TABLE;
                addr = {page_q, bus_byte};
            end else if (int_mode[0]) begin
                addr = VEC_W'(ADDR_PRI1);
            end else begin
                kind = VK_BUSOP;
            end
        end else if (win >= SRC_W'(SRC_SLOT0)) begin
            kind = VK_TABLE;
            addr = {page_q, slot_q, code};
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
// Top level of the vectored interrupt controller. Registers the winner of
// an acknowledge and holds it until the next one. Assumes ack is a pulse
// from the CPU and that external pins are already synchronous to clk.
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int N_AUX  = 2,
    parameter int N_INT  = 7,
    localparam int N_SRC = 3 + N_AUX + N_INT,
    localparam int SRC_W = $clog2(N_SRC),
    localparam int VEC_W = PAGE_W + 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [PAGE_W-1:0] cfg_wdata,
    input  logic              gie,
    input  logic [1:0]        int_mode,
    input  logic              undef_op,
    input  logic              undef_second,
    input  logic              nmi_pin,
    input  logic [N_AUX:0]    ext_pin,
    input  logic [N_INT-1:0]  int_req,
    input  logic [7:0]        bus_byte,
    input  logic              ack,
    output logic              irq_pending,
    output logic [SRC_W-1:0]  vec_src,
    output logic [1:0]        vec_kind,
    output logic [VEC_W-1:0]  vec_addr,
    output logic              trap_flag,
    output logic              trap_byte2
);
    logic [PAGE_W-1:0] page_q;
    logic [SLOT_W-1:0] slot_q;
    logic [N_AUX:0]    pin_en;
    logic [N_SRC-1:0]  eligible;
    logic              trap_pend, nmi_pend, any, grant;
    logic [SRC_W-1:0]  win;
    vkind_e            kind;
    logic [VEC_W-1:0]  addr;

    assign grant       = ack & any;
    assign irq_pending = any;

    irqv_regs #(.PAGE_W(PAGE_W), .N_AUX(N_AUX)) u_regs (
        .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .undef_op, .undef_second,
        .page_q, .slot_q, .pin_en, .trap_flag, .trap_byte2
    );

    irqv_req #(.N_AUX(N_AUX), .N_INT(N_INT)) u_req (
        .clk, .rst_n, .nmi_pin, .undef_op, .ext_pin, .int_req, .gie, .pin_en,
        .take_trap (grant && win == SRC_W'(SRC_TRAP)),
        .take_nmi  (grant && win == SRC_W'(SRC_NMI)),
        .eligible, .trap_pend, .nmi_pend
    );

    irqv_arb #(.N_SRC(N_SRC), .PAGE_W(PAGE_W)) u_arb (
        .eligible, .int_mode, .page_q, .slot_q, .bus_byte,
        .any, .win, .kind, .addr
    );

    // Vector output register: loads on a granted acknowledge, else holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_src  <= '0;
            vec_kind <= VK_RESTART;
            vec_addr <= '0;
        end else if (grant) begin
            vec_src  <= win;
            vec_kind <= kind;
            vec_addr <= addr;
        end
    end
endmodule

// File: rtl/irqv_chk.sv
// Assertion checker for irq_vector_ctrl, attached by bind below.
// Assumes the bound top uses PAGE_W-bit pages and a 4-bit source field.
module irqv_chk #(
    parameter int PAGE_W = 8,
    parameter int SRC_W  = 4,
    parameter int VEC_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic              gie,
    input logic              undef_op,
    input logic              irq_pending,
    input logic              trap_pend,
    input logic              trap_flag,
    input logic [PAGE_W-1:0] page_q,
    input logic [SRC_W-1:0]  vec_src,
    input logic [1:0]        vec_kind,
    input logic [VEC_W-1:0]  vec_addr
);
    // R9
    hold_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> $stable(vec_src) && $stable(vec_kind) && $stable(vec_addr));

    // R6
    trap_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        undef_op |=> trap_flag);

    // R2
    trap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack && trap_pend |=> vec_src == '0 && vec_addr == '0);

    // R3
    slot_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack && irq_pending |=> (vec_src < SRC_W'(3)) ||
                                (vec_addr[VEC_W-1 -: PAGE_W] == $past(page_q)));

    // R4
    nmi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack && irq_pending |=> (vec_src != SRC_W'(1)) || (vec_addr == VEC_W'(16'h0066)));

    // R8
    masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack && !gie |=> (vec_src <= SRC_W'(1)) || $stable(vec_src));
endmodule

bind irq_vector_ctrl irqv_chk #(.PAGE_W(PAGE_W), .SRC_W(SRC_W), .VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack         (ack),
    .gie         (gie),
    .undef_op    (undef_op),
    .irq_pending (irq_pending),
    .trap_pend   (trap_pend),
    .trap_flag   (trap_flag),
    .page_q      (page_q),
    .vec_src     (vec_src),
    .vec_kind    (vec_kind),
    .vec_addr    (vec_addr)
);

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected vector for each
// acknowledge, the monitor compares it one half-cycle after the edge.
module irq_vector_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [7:0]  cfg_wdata = 8'd0;
    logic        gie = 1'b0;
    logic [1:0]  int_mode = 2'd0;
    logic        undef_op = 1'b0;
    logic        undef_second = 1'b0;
    logic        nmi_pin = 1'b0;
    logic [2:0]  ext_pin = 3'd0;
    logic [6:0]  int_req = 7'd0;
    logic [7:0]  bus_byte = 8'd0;
    logic        ack = 1'b0;
    logic        irq_pending;
    logic [3:0]  vec_src;
    logic [1:0]  vec_kind;
    logic [15:0] vec_addr;
    logic        trap_flag, trap_byte2;

    typedef struct {
        int          src;
        int          kind;
        logic [15:0] addr;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic        ack_q = 1'b0;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;
    int          last_src = 0, last_kind = 0;
    logic [15:0] last_addr = 16'h0;
    logic [7:0]  page = 8'h00;
    logic [2:0]  slot = 3'd0;

    always #10 clk = ~clk;

    irq_vector_ctrl u_irq_vector_ctrl (
        .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .gie, .int_mode,
        .undef_op, .undef_second, .nmi_pin, .ext_pin, .int_req, .bus_byte,
        .ack, .irq_pending, .vec_src, .vec_kind, .vec_addr, .trap_flag, .trap_byte2
    );

    // Expected table address for slot source k (0 = auxiliary pin 1).
    function automatic logic [15:0] slot_addr(int k);
        return {page, slot, 5'(2 * k)};
    endfunction

    task automatic check_bit(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic cfg_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Driver: queue the expected result, then pulse acknowledge.
    task automatic take(int src, int kind, logic [15:0] addr, string tag);
        exp_t e;
        e.src = src; e.kind = kind; e.addr = addr; e.tag = tag;
        sb.push_back(e);
        last_src = src; last_kind = kind; last_addr = addr;
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic take_none(string tag);
        take(last_src, last_kind, last_addr, tag);
    endtask

    always @(posedge clk) ack_q <= ack;

    // Monitor: compare the registered vector after each acknowledge.
    always @(negedge clk) begin
        if (ack_q && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (vec_src !== 4'(e.src) || vec_kind !== 2'(e.kind) || vec_addr !== e.addr) begin
                n_bad++;
                $display("FAIL %s: got src %0d kind %0d addr %h expected src %0d kind %0d addr %h",
                         e.tag, vec_src, vec_kind, vec_addr, e.src, e.kind, e.addr);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        check_bit("R1 src zero", vec_src == 4'd0, 1'b1);
        check_bit("R1 addr zero", vec_addr == 16'h0 && vec_kind == 2'd0, 1'b1);
        check_bit("R1 trap_flag", trap_flag, 1'b0);
        check_bit("R1 trap_byte2", trap_byte2, 1'b0);
        check_bit("R11 idle pending", irq_pending, 1'b0);
        // R1: primary enabled by default, auxiliary disabled
        gie = 1'b1; int_mode = 2'd1; ext_pin = 3'b110;
        @(negedge clk);
        check_bit("R1 aux pins disabled", irq_pending, 1'b0);
        ext_pin = 3'b001;
        take(2, 0, 16'h0038, "R1 primary enabled at reset");
        ext_pin = 3'b000;

        // R10 configuration writes
        page = 8'h5A; slot = 3'b101;
        cfg_write(2'd0, page);
        cfg_write(2'd1, {5'b11111, slot});
        cfg_write(2'd2, 8'h87);

        // R3 each table-slot source alone
        ext_pin = 3'b010; take(3, 1, slot_addr(0), "R3 aux pin 1");
        ext_pin = 3'b100; take(4, 1, slot_addr(1), "R3 aux pin 2");
        ext_pin = 3'b000;
        for (int j = 0; j < 7; j++) begin
            int_req = 7'(1 << j);
            take(5 + j, 1, slot_addr(2 + j), "R3 internal line");
        end

        // R2 priority sweep, dropping the winner each time
        ext_pin = 3'b110; int_req = 7'h7F;
        for (int k = 0; k < 9; k++) begin
            take(3 + k, 1, slot_addr(k), "R2 priority sweep");
            if (k < 2) ext_pin[k+1] = 1'b0;
            else       int_req[k-2] = 1'b0;
        end
        @(negedge clk);
        check_bit("R11 none left", irq_pending, 1'b0);

        // R8 global enable masks maskable sources; R9 empty ack holds
        gie = 1'b0; int_req = 7'h01; ext_pin = 3'b111;
        @(negedge clk);
        check_bit("R11 masked not pending", irq_pending, 1'b0);
        take_none("R9 ack with nothing eligible");
        // R8 per-pin enables off: pins ignored, internal still taken
        cfg_write(2'd2, 8'h80);
        gie = 1'b1; int_req = 7'h00;
        @(negedge clk);
        check_bit("R8 pins disabled", irq_pending, 1'b0);
        int_req = 7'h04;
        take(7, 1, slot_addr(4), "R8 internal ungated by pin enables");
        int_req = 7'h00; ext_pin = 3'b000;

        // R5 primary pin modes
        cfg_write(2'd2, 8'h81);
        ext_pin = 3'b001;
        int_mode = 2'd1; take(2, 0, 16'h0038, "R5 mode 1 restart");
        int_mode = 2'd0; take(2, 2, 16'h0000, "R5 mode 0 bus opcode");
        int_mode = 2'd2; bus_byte = 8'hC4; take(2, 1, {page, 8'hC4}, "R5 mode 2 table");
        int_mode = 2'd3; bus_byte = 8'h3E; take(2, 1, {page, 8'h3E}, "R5 mode 3 table");
        ext_pin = 3'b000;

        // R4 edge-latched non-maskable, ignores gie, once per edge
        gie = 1'b0; nmi_pin = 1'b1;
        take(1, 0, 16'h0066, "R4 nmi entry");
        @(negedge clk);
        check_bit("R4 held pin no re-request", irq_pending, 1'b0);
        take_none("R4 held pin not taken again");
        nmi_pin = 1'b0;

        // R6 trap outranks everything and sets status
        gie = 1'b1; ext_pin = 3'b001; int_mode = 2'd1;
        @(negedge clk);
        nmi_pin = 1'b1; undef_op = 1'b1; undef_second = 1'b1;
        @(negedge clk);
        undef_op = 1'b0; undef_second = 1'b0;
        check_bit("R6 trap_flag set", trap_flag, 1'b1);
        check_bit("R6 trap_byte2 second", trap_byte2, 1'b1);
        take(0, 0, 16'h0000, "R6 R2 trap first");
        take(1, 0, 16'h0066, "R2 nmi next");
        take(2, 0, 16'h0038, "R2 primary after nmi");
        check_bit("R6 flag kept after ack", trap_flag, 1'b1);
        nmi_pin = 1'b0; ext_pin = 3'b000;

        // R7 software clear rules
        cfg_write(2'd2, 8'h81);
        check_bit("R7 bit7 one keeps flag", trap_flag, 1'b1);
        cfg_write(2'd2, 8'h01);
        check_bit("R7 bit7 zero clears flag", trap_flag, 1'b0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 8'h01; undef_op = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; undef_op = 1'b0;
        check_bit("R7 set wins over clear", trap_flag, 1'b1);
        check_bit("R6 first-byte trap", trap_byte2, 1'b0);
        take(0, 0, 16'h0000, "R6 trap after clear race");

        // R3 R10 new page and slot with the last code
        page = 8'h13; slot = 3'b010;
        cfg_write(2'd0, page);
        cfg_write(2'd1, {5'd0, slot});
        int_req = 7'h40;
        take(11, 1, 16'h1350, "R3 last slot code");
        int_req = 7'h00;

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule